// File: doc/BRIEF.md
# Positioned String Text Overlay

This block tells a video pipeline, pixel by pixel, whether the raster position being visited falls on a lit dot of a fixed text string. The string and its length are set at elaboration time. The string is drawn with an internal 128-glyph bitmap font, each glyph 8 pixels wide and 16 pixels tall. The top-left corner of the text box is given at run time as a pixel X/Y anchor.

Each clock of the pixel clock, the block takes the current horizontal and vertical raster coordinates. It works out which character of the string, which column and which row inside that glyph the pixel maps to. It then looks up the glyph row and registers a single on-text flag. The colour logic downstream uses that flag to pick the text colour or the background colour. Because the flag is registered, the caller delays its own pixel data by one clock to line up with it.

The font is a generated pattern rather than a stored table. For a nonzero character code c, glyph row r (1 to 14) is the 8-bit value {1, c[6:0]} rotated left by r mod 8. Rows 0 and 15 are blank, and code 0 is fully blank.

Top module: `ovl_text_overlay`

## Requirements
- R1: While rst_n is low, text_pixel is 0 whatever the coordinate inputs are.
- R2: text_pixel reflects the coordinates presented before the preceding rising clock edge: exactly one clock of latency.
- R3: The text box covers scan_x from anchor_x to anchor_x + 8*TEXT_LEN - 1 and scan_y from anchor_y to anchor_y + 15. Outside it, text_pixel is 0.
- R4: A coordinate left of anchor_x or above anchor_y gives 0, even when the unsigned difference would wrap into the box.
- R5: The character index is (scan_x - anchor_x) / 8. Index 0 is the first character of TEXT_STR, which sits in its most significant byte, and it is drawn leftmost.
- R6: The column inside a glyph is (scan_x - anchor_x) mod 8. Column 0 takes bit 7 of the glyph row.
- R7: For glyph row r = scan_y - anchor_y and nonzero code c, rows 1 to 14 are {1'b1, c[6:0]} rotated left by r mod 8, and rows 0 and 15 are all zero.
- R8: Character bytes at or above 128 are drawn as their low 7 bits.
- R9: Character code 0 draws no lit pixel anywhere in its cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| anchor_x | input | COORD_W | X of the text box's top-left corner |
| anchor_y | input | COORD_W | Y of the text box's top-left corner |
| scan_x | input | COORD_W | Current horizontal raster coordinate |
| scan_y | input | COORD_W | Current vertical raster coordinate |
| text_pixel | output | 1 | Registered flag: pixel lies on a lit text dot |

## Verification
The assertions assume the anchor and scan inputs are stable and free of X across each sampling edge. They also assume a glyph row is only meaningful while the locator reports the pixel inside the box. The bench changes every input only on the falling clock edge and keeps all coordinates within the unsigned COORD_W range. It sweeps a margin around the box at anchors that include the origin and the far corner of the coordinate space, so the wrap cases stay in legal values.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int GLYPH_W   = 8;
  localparam int GLYPH_H   = 16;
  localparam int CODE_W    = 7;
  localparam int ROW_IDX_W = $clog2(GLYPH_H);
  localparam int COL_IDX_W = $clog2(GLYPH_W);

  typedef logic [CODE_W-1:0]    code_t;
  typedef logic [GLYPH_W-1:0]   glyph_row_t;
  typedef logic [ROW_IDX_W-1:0] row_idx_t;
  typedef logic [COL_IDX_W-1:0] col_idx_t;

  // Generated font: blank border rows, rotated code pattern inside.
  function automatic glyph_row_t glyph_pattern(code_t code, row_idx_t row);
    glyph_row_t base;
    logic [2:0] sh;
    if (code == '0 || row == '0 || row == row_idx_t'(GLYPH_H - 1))
      return '0;
    base = {1'b1, code};
    sh   = row[2:0];
    return glyph_row_t'((base << sh) | (base >> (4'd8 - {1'b0, sh})));
  endfunction
endpackage

// File: rtl/ovl_glyph_rom.sv
module ovl_glyph_rom
  import ovl_pkg::*;
(
  input  code_t      code,
  input  row_idx_t   row,
  output glyph_row_t row_bits
);
  always_comb begin
    row_bits = glyph_pattern(code, row);
  end
endmodule

// File: rtl/ovl_locator.sv
module ovl_locator
  import ovl_pkg::*;
#(
  parameter int COORD_W  = 11,
  parameter int TEXT_LEN = 5,
  parameter int IDX_W    = 3
) (
  input  logic [COORD_W-1:0] anchor_x,
  input  logic [COORD_W-1:0] anchor_y,
  input  logic [COORD_W-1:0] scan_x,
  input  logic [COORD_W-1:0] scan_y,
  output logic               in_box,
  output logic [IDX_W-1:0]   char_idx,
  output col_idx_t           col,
  output row_idx_t           row
);
  localparam int SPAN_X = GLYPH_W * TEXT_LEN;

  logic [COORD_W:0]   dx, dy;
  logic               in_x, in_y;
  logic [COORD_W-4:0] cell_full;

  always_comb begin
    // One extra bit keeps the sign so a negative offset cannot wrap into the box.
    dx        = {1'b0, scan_x} - {1'b0, anchor_x};
    dy        = {1'b0, scan_y} - {1'b0, anchor_y};
    in_x      = !dx[COORD_W] && ({1'b0, dx[COORD_W-1:0]} < (COORD_W+1)'(SPAN_X));
    in_y      = !dy[COORD_W] && ({1'b0, dy[COORD_W-1:0]} < (COORD_W+1)'(GLYPH_H));
    in_box    = in_x && in_y;
    cell_full = dx[COORD_W-1:3];
    char_idx  = cell_full[IDX_W-1:0];
    col       = dx[2:0];
    row       = dy[3:0];
  end
endmodule

// File: rtl/ovl_char_select.sv
module ovl_char_select
  import ovl_pkg::*;
#(
  parameter int                    TEXT_LEN = 5,
  parameter int                    IDX_W    = 3,
  parameter logic [8*TEXT_LEN-1:0] TEXT_STR = "Hello"
) (
  input  logic [IDX_W-1:0] char_idx,
  output code_t            code
);
  code_t chars [TEXT_LEN];

  // Leftmost character lives in the most significant byte; only 7 bits kept.
  for (genvar k = 0; k < TEXT_LEN; k++) begin : g_char
    assign chars[k] = TEXT_STR[8*(TEXT_LEN-1-k) +: CODE_W];
  end

  always_comb begin
    code = '0;
    for (int k = 0; k < TEXT_LEN; k++) begin
      if (char_idx == IDX_W'(k)) code = chars[k];
    end
  end
endmodule

// File: rtl/ovl_text_overlay.sv
module ovl_text_overlay
  import ovl_pkg::*;
#(
  parameter int                    COORD_W  = 11,
  parameter int                    TEXT_LEN = 5,
  parameter logic [8*TEXT_LEN-1:0] TEXT_STR = "Hello"
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] anchor_x,
  input  logic [COORD_W-1:0] anchor_y,
  input  logic [COORD_W-1:0] scan_x,
  input  logic [COORD_W-1:0] scan_y,
  output logic               text_pixel
);
  localparam int IDX_W = (TEXT_LEN > 1) ? $clog2(TEXT_LEN) : 1;

  logic             in_box;
  logic [IDX_W-1:0] char_idx;
  col_idx_t         col;
  row_idx_t         row;
  code_t            code;
  glyph_row_t       row_bits;
  logic             hit_d;

  ovl_locator #(.COORD_W(COORD_W), .TEXT_LEN(TEXT_LEN), .IDX_W(IDX_W)) u_loc (
    .anchor_x (anchor_x),
    .anchor_y (anchor_y),
    .scan_x   (scan_x),
    .scan_y   (scan_y),
    .in_box   (in_box),
    .char_idx (char_idx),
    .col      (col),
    .row      (row)
  );

  ovl_char_select #(.TEXT_LEN(TEXT_LEN), .IDX_W(IDX_W), .TEXT_STR(TEXT_STR)) u_sel (
    .char_idx (char_idx),
    .code     (code)
  );

  ovl_glyph_rom u_rom (
    .code     (code),
    .row      (row),
    .row_bits (row_bits)
  );

  // Next state: bit 7 of the glyph row is the leftmost column.
  always_comb begin
    hit_d = 1'b0;
    if (in_box) hit_d = row_bits[3'd7 - col];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) text_pixel <= 1'b0;
    else        text_pixel <= hit_d;
  end

  a_r3_outside_box_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !in_box |=> !text_pixel);
  a_r4_left_of_anchor: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_x < anchor_x) |=> !text_pixel);
  a_r4_above_anchor: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_y < anchor_y) |=> !text_pixel);
  a_r5_index_in_string: assert property (@(posedge clk) disable iff (!rst_n)
    in_box |-> (int'(char_idx) < TEXT_LEN));
  a_r9_blank_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0) |-> (row_bits == '0));
  a_r7_border_rows_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (row == '0 || row == row_idx_t'(GLYPH_H - 1)) |-> (row_bits == '0));
endmodule

// File: tb/sim_ovl_text_overlay.sv
module sim_ovl_text_overlay;
  localparam int COORD_W  = 11;
  localparam int TEXT_LEN = 4;
  localparam logic [31:0] STR = {8'h41, 8'hC5, 8'h00, 8'h7F};
  localparam int MAXC = 1 << COORD_W;

  logic clk = 1'b0;
  logic rst_n;
  logic [COORD_W-1:0] anchor_x, anchor_y, scan_x, scan_y;
  logic text_pixel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ovl_text_overlay #(.COORD_W(COORD_W), .TEXT_LEN(TEXT_LEN), .TEXT_STR(STR)) u0 (
    .clk(clk), .rst_n(rst_n), .anchor_x(anchor_x), .anchor_y(anchor_y),
    .scan_x(scan_x), .scan_y(scan_y), .text_pixel(text_pixel)
  );

  function automatic int str_byte(int k);
    return int'(STR[8*(TEXT_LEN-1-k) +: 8]);
  endfunction

  // Model from R3..R9, returns expected pixel and a requirement tag.
  function automatic bit model(int ax, int ay, int x, int y, output string tag);
    int dx, dy, k, c, col, row, base, sh, rb;
    dx = x - ax; dy = y - ay;
    if (dx < 0 || dy < 0) begin tag = "R4"; return 1'b0; end
    if (dx >= 8*TEXT_LEN || dy >= 16) begin tag = "R3"; return 1'b0; end
    k = dx / 8; col = dx % 8; row = dy;
    c = str_byte(k) % 128;
    tag = (c == 0) ? "R9" : (str_byte(k) >= 128) ? "R8" : (col == 0) ? "R6" : (k > 0) ? "R5" : "R7";
    if (c == 0 || row == 0 || row == 15) return 1'b0;
    base = 128 + c; sh = row % 8;
    rb = ((base << sh) | (base >> (8 - sh))) % 256;
    return bit'((rb >> (7 - col)) & 1);
  endfunction

  task automatic check(bit exp, string tag, string what);
    checks++;
    if (text_pixel !== exp) begin
      failures++;
      $display("FAIL %s %s: got %b expected %b", tag, what, text_pixel, exp);
    end
  endtask

  task automatic sweep(int ax, int ay);
    bit pexp = 0, have = 0;
    string ptag = "", t;
    anchor_x = COORD_W'(ax); anchor_y = COORD_W'(ay);
    for (int y = ay - 3; y <= ay + 18; y++) begin
      for (int x = ax - 10; x <= ax + 8*TEXT_LEN + 10; x++) begin
        int xm, ym;
        xm = ((x % MAXC) + MAXC) % MAXC;
        ym = ((y % MAXC) + MAXC) % MAXC;
        @(negedge clk);
        if (have) check(pexp, ptag, "sweep");
        scan_x = COORD_W'(xm); scan_y = COORD_W'(ym);
        pexp = model(ax, ay, xm, ym, t); ptag = t; have = 1;
      end
    end
    @(negedge clk);
    check(pexp, ptag, "sweep end");
  endtask

  initial begin
    rst_n = 1'b0;
    anchor_x = 11'd5; anchor_y = 11'd3; scan_x = 11'd5; scan_y = 11'd4;
    // R1: a lit point is presented, output must stay low in reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(1'b0, "R1", "reset");
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b1, "R7", "lit dot A row1 col0");
    // R2: latency, change to miss and look before and after the edge
    scan_x = 11'd0;
    #5 check(1'b1, "R2", "before edge");
    @(negedge clk);
    check(1'b0, "R2", "after edge");
    sweep(5, 3);
    sweep(0, 0);
    sweep(2036, 2040);
    sweep(2040, 5);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule